// File: doc/BRIEF.md
# BCD calendar counter

This block holds wall-clock time and calendar date as seven packed-BCD bytes: seconds, minutes, hours, day of week, date, month and year. A single-cycle `tick` input, one pulse per second from an external prescaler, moves the count forward by one second. Carries run from seconds through minutes, hours and days into months and years. The month length is corrected for 30-day months and for February. A bit in the month byte records each wrap of the two-digit year.

Software or a bus bridge loads any byte through a simple addressed write port. All seven bytes are visible at the outputs at all times. A one-cycle `advanced` strobe follows every accepted tick, so that alarm comparators downstream know when to compare.

The hour byte runs in one of two formats, chosen by its bit 6. When bit 6 is 0 the byte is 24-hour BCD. When bit 6 is 1 the byte is 12-hour BCD, and bit 5 is the afternoon flag.

Top module: `bcd_calendar`

## Requirements
- R1: A synchronous active-low reset sets seconds 0x00, minutes 0x00, hours 0x00 (24-hour), weekday 0x01, date 0x01, month 0x01, year 0x00, and `advanced` low.
- R2: Seconds and minutes count 00..59 in BCD. Each one wraps from 59 to 00 and carries into the next field.
- R3: With hours bit 6 = 0, hours count 00..23. Bits 5:4 are the tens digit and bits 3:0 are the units. A step from 23 to 00 advances the day.
- R4: With hours bit 6 = 1, bits 4:0 hold 1..12 in BCD and bit 5 is the PM flag (1 = PM). A step from 11 to 12 inverts bit 5. A step from 12 to 1 leaves bit 5 unchanged. The day advances only on the step from 11 PM to 12 AM.
- R5: The weekday counts 1..7 in bits 2:0 and goes back to 1 after 7 on each day advance.
- R6: The date wraps to 01 and advances the month after day 31 in months 1, 3, 5, 7, 8, 10 and 12, and after day 30 in months 4, 6, 9 and 11.
- R7: February ends on day 29 when the year value is divisible by 4, year 00 included. Otherwise it ends on day 28.
- R8: The month (bits 4:0) counts 1..12 and wraps to 1, which advances the year. The year counts 00..99.
- R9: Month bit 7 inverts every time the year wraps from 99 to 00.
- R10: Write addresses select the field: 0 seconds, 1 minutes, 2 hours, 3 weekday, 4 date, 5 month, 6 year. Stored bytes keep only these bits: 0x7F for seconds, minutes and hours, 0x07 for weekday, 0x3F for date, 0x9F for month, 0xFF for year. A write to address 7 changes nothing.
- R11: When a write to addresses 0..6 and a tick fall in the same cycle, the written value is stored, no field advances, and `advanced` stays low.
- R12: `advanced` is high for exactly one cycle after each accepted tick, in the same cycle as the updated count, and low at all other times.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| tick | input | 1 | One-second advance pulse |
| wr_en | input | 1 | Write strobe |
| wr_addr | input | 3 | Field select for writes |
| wr_data | input | 8 | Byte to write |
| seconds | output | 8 | Seconds, BCD |
| minutes | output | 8 | Minutes, BCD |
| hours | output | 8 | Hours with format bit and PM/tens bit |
| weekday | output | 8 | Day of week, 1..7 |
| date | output | 8 | Day of month, BCD |
| month | output | 8 | Month in BCD plus century bit 7 |
| year | output | 8 | Year, BCD |
| advanced | output | 1 | One-cycle strobe after a tick update |

## Verification
Every field is a register that drives an output directly, so a wrong stored value shows on the ports in the cycle after the faulty update. A wrong carry, by contrast, may stay hidden until the field overflows. A month-length or leap error therefore shows only at the end of a month. A lost PM flip shows only at noon or midnight. For this reason the vectors start each case one second before a rollover edge, so a carry fault shows after a single tick instead of after simulated days. A wrong tick/write priority shows as a missing or extra `advanced` pulse in the same cycle.

// File: rtl/cal_pkg.sv
// Shared constants and BCD helper functions for the calendar counter.
// Assumes packed BCD with the tens digit in the upper nibble.
package cal_pkg;
    localparam int BYTE_W   = 8;
    localparam int ADDR_W   = 3;
    localparam logic [ADDR_W-1:0] SEL_SEC   = 3'd0;
    localparam logic [ADDR_W-1:0] SEL_MIN   = 3'd1;
    localparam logic [ADDR_W-1:0] SEL_HOUR  = 3'd2;
    localparam logic [ADDR_W-1:0] SEL_DOW   = 3'd3;
    localparam logic [ADDR_W-1:0] SEL_DATE  = 3'd4;
    localparam logic [ADDR_W-1:0] SEL_MONTH = 3'd5;
    localparam logic [ADDR_W-1:0] SEL_YEAR  = 3'd6;

    localparam logic [BYTE_W-1:0] MASK_SM    = 8'h7F;
    localparam logic [BYTE_W-1:0] MASK_HOUR  = 8'h7F;
    localparam logic [BYTE_W-1:0] MASK_DOW   = 8'h07;
    localparam logic [BYTE_W-1:0] MASK_DATE  = 8'h3F;
    localparam logic [BYTE_W-1:0] MASK_MONTH = 8'h9F;
    localparam logic [BYTE_W-1:0] MASK_YEAR  = 8'hFF;

    // Packed BCD byte to binary value.
    function automatic logic [7:0] bcd_to_bin(input logic [7:0] b);
        return {4'd0, b[7:4]} * 8'd10 + {4'd0, b[3:0]};
    endfunction

    // Packed BCD byte plus one (no range wrap).
    function automatic logic [7:0] bcd_inc(input logic [7:0] b);
        if (b[3:0] >= 4'd9)
            return {b[7:4] + 4'd1, 4'd0};
        else
            return {b[7:4], b[3:0] + 4'd1};
    endfunction

    // Leap test on a BCD year: binary value divisible by four.
    function automatic logic is_leap(input logic [7:0] yr);
        logic [7:0] v;
        v = bcd_to_bin(yr);
        return (v[1:0] == 2'b00);
    endfunction

    // Last day number of a month given as 5-bit BCD.
    function automatic logic [7:0] month_days(input logic [4:0] mo, input logic leap);
        case (bcd_to_bin({3'b000, mo}))
            8'd2:                    return leap ? 8'd29 : 8'd28;
            8'd4, 8'd6, 8'd9, 8'd11: return 8'd30;
            default:                 return 8'd31;
        endcase
    endfunction
endpackage

// File: rtl/cal_wrap_ctr.sv
// Generic packed-BCD wrapping counter, used for seconds, minutes,
// weekday and year. It counts FIRST..LAST, wraps back to FIRST and
// flags the wrap. A load overrides a step. Loaded values are masked
// with MASK. Any stored value at or past LAST wraps on the next step.
module cal_wrap_ctr
    import cal_pkg::*;
#(
    parameter int FIRST = 0,
    parameter int LAST  = 59,
    parameter logic [7:0] MASK = 8'h7F
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       step,
    input  logic       load,
    input  logic [7:0] load_val,
    output logic [7:0] value,
    output logic       wrap
);
    localparam logic [7:0] FIRST_BCD = 8'((FIRST / 10) * 16 + (FIRST % 10));
    localparam logic [7:0] LAST_BIN  = 8'(LAST);

    logic at_last;

    // Flag that the next step must wrap.
    assign at_last = (bcd_to_bin(value) >= LAST_BIN);
    assign wrap    = step && at_last;

    // Count register: reset, load, then step.
    always_ff @(posedge clk) begin
        if (!rst_n)
            value <= FIRST_BCD;
        else if (load)
            value <= load_val & MASK;
        else if (step)
            value <= at_last ? FIRST_BCD : (bcd_inc(value) & MASK);
    end

    // R2
    count_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (step && !load && !at_last) |=> (bcd_to_bin(value) == bcd_to_bin($past(value)) + 8'd1));

    // R5
    wrap_first_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (step && !load && at_last) |=> (value == FIRST_BCD));
endmodule

// File: rtl/cal_hour.sv
// Hour register with 24-hour and 12-hour formats chosen by bit 6.
// In 12-hour format bit 5 is PM. It flips on 11->12, and the day
// carries on 11 PM -> 12 AM. Assumes the stored hour is in range
// for its format; out-of-range values fold to the start on a step.
module cal_hour
    import cal_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       step,
    input  logic       load,
    input  logic [7:0] load_val,
    output logic [7:0] hour,
    output logic       day_carry
);
    logic       mode12;
    logic       pm;
    logic [7:0] bin24;
    logic [7:0] bin12;
    logic [7:0] inc24;
    logic [7:0] inc12;
    logic [7:0] next_hour;
    logic       wrap_day;

    assign mode12 = hour[6];
    assign pm     = hour[5];
    assign bin24  = bcd_to_bin({2'b00, hour[5:0]});
    assign bin12  = bcd_to_bin({3'b000, hour[4:0]});
    assign inc24  = bcd_inc({2'b00, hour[5:0]});
    assign inc12  = bcd_inc({3'b000, hour[4:0]});

    // Next hour value and day carry for either format.
    always_comb begin
        next_hour = hour;
        wrap_day  = 1'b0;
        if (!mode12) begin
            if (bin24 >= 8'd23) begin
                next_hour = 8'h00;
                wrap_day  = 1'b1;
            end else begin
                next_hour = {2'b00, inc24[5:0]};
            end
        end else begin
            if (bin12 >= 8'd12) begin
                next_hour = {2'b01, pm, 5'h01};
            end else if (bin12 == 8'd11) begin
                next_hour = {2'b01, ~pm, 5'h12};
                wrap_day  = pm;
            end else begin
                next_hour = {2'b01, pm, inc12[4:0]};
            end
        end
    end

    assign day_carry = step && wrap_day;

    // Hour register: reset, load, then step.
    always_ff @(posedge clk) begin
        if (!rst_n)
            hour <= 8'h00;
        else if (load)
            hour <= load_val & MASK_HOUR;
        else if (step)
            hour <= next_hour;
    end

    // R4
    pm_flip_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (step && !load && hour[6] && hour[4:0] == 5'h11)
        |=> (hour[5] != $past(hour[5]) && hour[4:0] == 5'h12));

    // R4
    noon_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (step && !load && hour[6] && hour[4:0] == 5'h12)
        |=> (hour[5] == $past(hour[5]) && hour[4:0] == 5'h01));

    // R3
    mode24_stay_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (step && !load && !hour[6]) |=> (!hour[6] && bcd_to_bin({2'b00, hour[5:0]}) <= 8'd23));
endmodule

// File: rtl/cal_day.sv
// Date and month registers. The month length depends on the month and
// on a divide-by-four leap test of the current year. Month bit 7 is a
// century marker that inverts on a year wrap. The block steps once per
// day advance and reports a month wrap so that the year can advance.
module cal_day
    import cal_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       step,
    input  logic       date_load,
    input  logic       month_load,
    input  logic [7:0] load_val,
    input  logic [7:0] year,
    input  logic       century_flip,
    output logic [7:0] date,
    output logic [7:0] month,
    output logic       month_wrap
);
    logic [7:0] last_day;
    logic       date_last;
    logic       month_last;

    assign last_day   = month_days(month[4:0], is_leap(year));
    assign date_last  = (bcd_to_bin({2'b00, date[5:0]}) >= last_day);
    assign month_last = (bcd_to_bin({3'b000, month[4:0]}) >= 8'd12);
    assign month_wrap = step && date_last && month_last;

    // Date register: reset, load, then daily step.
    always_ff @(posedge clk) begin
        if (!rst_n)
            date <= 8'h01;
        else if (date_load)
            date <= load_val & MASK_DATE;
        else if (step)
            date <= date_last ? 8'h01 : (bcd_inc(date) & MASK_DATE);
    end

    // Month register: reset, load, then month step and century toggle.
    always_ff @(posedge clk) begin
        if (!rst_n)
            month <= 8'h01;
        else if (month_load)
            month <= load_val & MASK_MONTH;
        else begin
            if (step && date_last)
                month[4:0] <= month_last ? 5'h01 : (bcd_inc({3'b000, month[4:0]}) & 8'h1F);
            if (century_flip)
                month[7] <= ~month[7];
        end
    end

    // R6
    date_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (step && !date_load && !date_last)
        |=> (bcd_to_bin(date) == bcd_to_bin($past(date)) + 8'd1));

    // R7
    feb_len_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (step && !date_load && month[4:0] == 5'h02 && date == 8'h28 && is_leap(year))
        |=> (date == 8'h29));

    // R9
    century_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (century_flip && !month_load) |=> (month[7] != $past(month[7])));
endmodule

// File: rtl/bcd_calendar.sv
// Top level of the BCD calendar counter. It decodes the write port,
// gates the second tick so that a write wins, chains the field carries
// and registers the one-cycle advanced strobe. Assumes tick is a
// single-cycle pulse that is synchronous to clk.
module bcd_calendar
    import cal_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       tick,
    input  logic       wr_en,
    input  logic [2:0] wr_addr,
    input  logic [7:0] wr_data,
    output logic [7:0] seconds,
    output logic [7:0] minutes,
    output logic [7:0] hours,
    output logic [7:0] weekday,
    output logic [7:0] date,
    output logic [7:0] month,
    output logic [7:0] year,
    output logic       advanced
);
    logic wr_hit;
    logic step_sec;
    logic sec_wrap, min_wrap, day_step, dow_wrap, month_wrap, year_wrap;

    // A write to a real field blocks the tick for that cycle.
    assign wr_hit   = wr_en && (wr_addr <= SEL_YEAR);
    assign step_sec = tick && !wr_hit;

    cal_wrap_ctr #(.FIRST(0), .LAST(59), .MASK(MASK_SM)) u_sec (
        .clk(clk), .rst_n(rst_n), .step(step_sec),
        .load(wr_hit && wr_addr == SEL_SEC), .load_val(wr_data),
        .value(seconds), .wrap(sec_wrap));

    cal_wrap_ctr #(.FIRST(0), .LAST(59), .MASK(MASK_SM)) u_min (
        .clk(clk), .rst_n(rst_n), .step(sec_wrap),
        .load(wr_hit && wr_addr == SEL_MIN), .load_val(wr_data),
        .value(minutes), .wrap(min_wrap));

    cal_hour u_hour (
        .clk(clk), .rst_n(rst_n), .step(min_wrap),
        .load(wr_hit && wr_addr == SEL_HOUR), .load_val(wr_data),
        .hour(hours), .day_carry(day_step));

    cal_wrap_ctr #(.FIRST(1), .LAST(7), .MASK(MASK_DOW)) u_dow (
        .clk(clk), .rst_n(rst_n), .step(day_step),
        .load(wr_hit && wr_addr == SEL_DOW), .load_val(wr_data),
        .value(weekday), .wrap(dow_wrap));

    cal_day u_day (
        .clk(clk), .rst_n(rst_n), .step(day_step),
        .date_load(wr_hit && wr_addr == SEL_DATE),
        .month_load(wr_hit && wr_addr == SEL_MONTH),
        .load_val(wr_data), .year(year), .century_flip(year_wrap),
        .date(date), .month(month), .month_wrap(month_wrap));

    cal_wrap_ctr #(.FIRST(0), .LAST(99), .MASK(MASK_YEAR)) u_year (
        .clk(clk), .rst_n(rst_n), .step(month_wrap),
        .load(wr_hit && wr_addr == SEL_YEAR), .load_val(wr_data),
        .value(year), .wrap(year_wrap));

    // Strobe register: high the cycle after an accepted tick.
    always_ff @(posedge clk) begin
        if (!rst_n)
            advanced <= 1'b0;
        else
            advanced <= step_sec;
    end

    // R12
    strobe_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
        advanced |-> ($past(tick) && !$past(wr_hit)));

    // R11
    write_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_hit && tick) |=> !advanced);

    // R5
    dow_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (dow_wrap && !wr_hit) |=> (weekday == 8'h01 && date != 8'h00));
endmodule

// File: tb/sim_bcd_calendar.sv
`timescale 1ns/1ps
// Bench for bcd_calendar: a table of load/tick/expect vectors, then
// directed checks for reset, write masking, priority and the strobe.
module sim_bcd_calendar;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       tick = 1'b0;
    logic       wr_en = 1'b0;
    logic [2:0] wr_addr = 3'd0;
    logic [7:0] wr_data = 8'd0;
    logic [7:0] seconds, minutes, hours, weekday, date, month, year;
    logic       advanced;
    int checks = 0;
    int errors = 0;
    int cycles = 0;

    always #2 clk = ~clk;

    bcd_calendar u0 (
        .clk(clk), .rst_n(rst_n), .tick(tick), .wr_en(wr_en),
        .wr_addr(wr_addr), .wr_data(wr_data), .seconds(seconds),
        .minutes(minutes), .hours(hours), .weekday(weekday), .date(date),
        .month(month), .year(year), .advanced(advanced));

    // Packed view {year, month, date, weekday, hours, minutes, seconds}.
    logic [55:0] now;
    assign now = {year, month, date, weekday, hours, minutes, seconds};

    localparam int NV = 24;
    localparam logic [55:0] VPRE [NV] = '{
        56'h00_01_01_01_00_00_00, 56'h00_01_01_01_00_00_59,   // R2
        56'h00_01_01_01_00_59_59, 56'h00_01_01_01_09_59_59,   // R2, R3
        56'h00_01_01_01_19_59_59, 56'h00_06_05_03_23_59_59,   // R3
        56'h00_03_10_07_23_59_59,                             // R5
        56'h00_01_01_01_51_59_59, 56'h00_01_01_01_72_59_59,   // R4
        56'h00_07_15_02_71_59_59, 56'h00_01_01_01_52_59_59,   // R4
        56'h00_01_01_01_49_59_59,                             // R4
        56'h00_01_31_01_23_59_59, 56'h00_04_30_01_23_59_59,   // R6
        56'h00_04_29_01_23_59_59,                             // R6
        56'h23_02_28_01_23_59_59, 56'h24_02_28_01_23_59_59,   // R7
        56'h24_02_29_01_23_59_59, 56'h00_02_28_01_23_59_59,   // R7
        56'h09_12_31_01_23_59_59,                             // R8
        56'h99_12_31_01_23_59_59, 56'h99_92_31_01_23_59_59,   // R9
        56'h00_09_30_01_23_59_59, 56'h00_11_30_01_23_59_59    // R8, R6
    };
    localparam logic [55:0] VPOST [NV] = '{
        56'h00_01_01_01_00_00_01, 56'h00_01_01_01_00_01_00,
        56'h00_01_01_01_01_00_00, 56'h00_01_01_01_10_00_00,
        56'h00_01_01_01_20_00_00, 56'h00_06_06_04_00_00_00,
        56'h00_03_11_01_00_00_00,
        56'h00_01_01_01_72_00_00, 56'h00_01_01_01_61_00_00,
        56'h00_07_16_03_52_00_00, 56'h00_01_01_01_41_00_00,
        56'h00_01_01_01_50_00_00,
        56'h00_02_01_02_00_00_00, 56'h00_05_01_02_00_00_00,
        56'h00_04_30_02_00_00_00,
        56'h23_03_01_02_00_00_00, 56'h24_02_29_02_00_00_00,
        56'h24_03_01_02_00_00_00, 56'h00_02_29_02_00_00_00,
        56'h10_01_01_02_00_00_00,
        56'h00_81_01_02_00_00_00, 56'h00_01_01_02_00_00_00,
        56'h00_10_01_02_00_00_00, 56'h00_12_01_02_00_00_00
    };
    string vreq [NV] = '{
        "R2", "R2", "R2", "R3", "R3", "R3", "R5",
        "R4", "R4", "R4", "R4", "R4",
        "R6", "R6", "R6", "R7", "R7", "R7", "R7",
        "R8", "R9", "R9", "R8", "R6"
    };

    task automatic chk(input string req, input logic [55:0] act, input logic [55:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic write_byte(input logic [2:0] a, input logic [7:0] d);
        @(negedge clk);
        wr_en = 1'b1; wr_addr = a; wr_data = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic load_all(input logic [55:0] v);
        for (int i = 0; i < 7; i++)
            write_byte(3'(i), v[i*8 +: 8]);
    endtask

    // One tick; returns at the negedge where the update is visible.
    task automatic do_tick();
        @(negedge clk);
        tick = 1'b1;
        @(negedge clk);
        tick = 1'b0;
    endtask

    // Watchdog: a hung run is a failed check and still reports.
    always @(posedge clk) begin
        cycles++;
        if (cycles == 100000) begin
            checks++;
            errors++;
            $display("FAIL watchdog actual %0d cycles expected fewer", cycles);
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        // R1: reset values
        chk("R1", now, 56'h00_01_01_01_00_00_00);
        chk("R1", {55'd0, advanced}, 56'd0);

        // Vector table: load one second before an edge, tick once.
        for (int k = 0; k < NV; k++) begin
            load_all(VPRE[k]);
            do_tick();
            chk(vreq[k], now, VPOST[k]);
        end

        // R10: masking of unused bits on writes
        write_byte(3'd0, 8'hFF);
        chk("R10", {48'd0, seconds}, 56'h7F);
        write_byte(3'd2, 8'hFF);
        chk("R10", {48'd0, hours}, 56'h7F);
        write_byte(3'd3, 8'hFF);
        chk("R10", {48'd0, weekday}, 56'h07);
        write_byte(3'd4, 8'hFF);
        chk("R10", {48'd0, date}, 56'h3F);
        write_byte(3'd5, 8'hFF);
        chk("R10", {48'd0, month}, 56'h9F);

        // R10: address 7 leaves every field untouched
        load_all(56'h42_05_17_04_13_27_38);
        write_byte(3'd7, 8'hAA);
        chk("R10", now, 56'h42_05_17_04_13_27_38);

        // R11: write and tick in the same cycle
        load_all(56'h00_01_01_01_00_00_10);
        @(negedge clk);
        wr_en = 1'b1; wr_addr = 3'd0; wr_data = 8'h30; tick = 1'b1;
        @(negedge clk);
        wr_en = 1'b0; tick = 1'b0;
        chk("R11", now, 56'h00_01_01_01_00_00_30);
        chk("R11", {55'd0, advanced}, 56'd0);

        // R12: strobe high for one cycle after a lone tick
        do_tick();
        chk("R12", {48'd0, seconds}, 56'h31);
        chk("R12", {55'd0, advanced}, 56'd1);
        @(negedge clk);
        chk("R12", {55'd0, advanced}, 56'd0);

        // R2: long run of ticks across two minute carries
        load_all(56'h00_01_01_01_00_00_00);
        for (int t = 0; t < 130; t++)
            do_tick();
        chk("R2", now, 56'h00_01_01_01_00_02_10);

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule